// File: doc/BRIEF.md
# Sixteen-Bit Capture/Compare Timer

This block is a 16-bit up-counter with two compare channels and one capture channel. It is programmed through a narrow register port with a byte-wide data path. A control field picks what advances the counter: nothing, every system clock, an enable strobe from an outside prescaler, or one chosen edge of an external pin. The external pin is first brought into the system clock domain by a synchronizer.

Each compare channel checks the counter against its own 16-bit value at full width. On a match it raises a flag and applies a programmable action to its output pin. Software can also apply that pin action through force bits, without a real match. Compare channel A can return the counter to zero on a match. The capture channel stores the counter value when the chosen edge appears on the capture input. An optional filter on that input rejects short pulses.

There are four flags: overflow, compare A, compare B and capture. Each flag has a mask bit, and the masked flags are combined into one interrupt line. A 16-bit register is read or written as two bytes through one shared holding byte, so that both halves belong to the same moment.

Top module: `timer16_cc`

Register map (addr_i):
- 0, pin actions: bits [1:0] action A, bits [3:2] action B. Action codes are 0 none, 1 toggle, 2 drive low, 3 drive high. Writing 1 to bit 6 forces channel A and writing 1 to bit 7 forces channel B. The force bits always read as 0.
- 1, control: bits [2:0] clock select, bit 3 clear on compare A, bit 4 capture edge (1 rising, 0 falling), bit 5 capture filter enable. Clock select codes are 0 stopped, 1 system clock, 2 prescaler strobe, 3 external falling edge, 4 external rising edge. Codes 5, 6 and 7 also stop the counter.
- 2, flags and 3, mask: bit 0 overflow, bit 1 compare A, bit 2 compare B, bit 3 capture.
- 4/5 counter, 6/7 compare A, 8/9 compare B, 10/11 capture. In each pair the even address is the low byte and the odd address is the high byte.

## Requirements
- R1: After reset every register reads 0, irq_o is low, and both compare pins are low.
- R2: The counter increments by one for each enable from the selected source. Code 1 gives an enable every cycle and code 2 gives one per presc_stb_i pulse. With code 0 or codes 5 to 7 the counter holds its value.
- R3: With code 4 the counter advances once for each rising edge of ext_clk_i, and with code 3 once for each falling edge. The edge counts after the synchronizer. Each pin level must be held for at least two system clock periods.
- R4: An enable that finds the counter at 0xFFFF wraps it to 0x0000 and sets flag bit 0.
- R5: An enable that finds the counter equal to compare A sets flag bit 1. An enable that finds it equal to compare B sets flag bit 2.
- R6: When control bit 3 is set, an enable that finds the counter equal to compare A loads 0 into the counter instead of incrementing it.
- R7: On a compare match, or on a write of 1 to that channel's force bit, the channel's pin takes the action already programmed. A force sets no flag.
- R8: The selected edge of cap_i, after the synchronizer, copies the counter into the capture register and sets flag bit 3. The opposite edge has no effect.
- R9: With control bit 5 set, the capture input changes level only after four consecutive equal samples. A pulse of two cycles then causes no capture.
- R10: Writing 1 to a bit of the flag register clears that flag. Writing 0 leaves it unchanged.
- R11: irq_o is high exactly when some flag and its mask bit are both set.
- R12: Writing a high byte only loads the holding byte. Writing the low byte commits the holding byte and the low byte together. Reading a low byte copies the matching high byte into the holding byte, and a high-byte read returns the holding byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (updates the holding byte on low-byte reads) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| presc_stb_i | input | 1 | Count enable strobe from an outside prescaler |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| cap_i | input | 1 | Capture trigger pin, asynchronous |
| cmp_a_o | output | 1 | Compare channel A pin |
| cmp_b_o | output | 1 | Compare channel B pin |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The counter is driven by known numbers of prescaler pulses, spaced external pin edges of each polarity, and free-running cycles. Comparing the final counts separates the sources from each other and from a stopped counter. The compare setup places compare B just below compare A, so the flag bits show which comparator fired and on which enable, and the clear-on-match run shows the counter restarting. Capture is driven with long edges of both polarities and with two-cycle pulses, with the filter on and off. This tells edge selection apart from filtering. Reading the counter across a count step shows whether the holding byte keeps the high half from the low-byte read.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_SYS      = 3'd1,
    CS_PRE      = 3'd2,
    CS_EXT_FALL = 3'd3,
    CS_EXT_RISE = 3'd4
  } clk_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } pin_act_e;

  localparam logic [3:0] A_PIN_ACT = 4'd0;
  localparam logic [3:0] A_CTRL    = 4'd1;
  localparam logic [3:0] A_FLAGS   = 4'd2;
  localparam logic [3:0] A_MASK    = 4'd3;
  localparam logic [3:0] A_CNT_LO  = 4'd4;
  localparam logic [3:0] A_CNT_HI  = 4'd5;
  localparam logic [3:0] A_CMPA_LO = 4'd6;
  localparam logic [3:0] A_CMPA_HI = 4'd7;
  localparam logic [3:0] A_CMPB_LO = 4'd8;
  localparam logic [3:0] A_CMPB_HI = 4'd9;
  localparam logic [3:0] A_CAP_LO  = 4'd10;
  localparam logic [3:0] A_CAP_HI  = 4'd11;

  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned F_OVF  = 0;
  localparam int unsigned F_CMPA = 1;
  localparam int unsigned F_CMPB = 2;
  localparam int unsigned F_CAP  = 3;
endpackage

// File: rtl/timer16_edge_sync.sv
module timer16_edge_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned FILT   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic filt_en_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [FILT-1:0]   hist_q;
  logic              level_q, prev_q, samp;

  assign samp = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      hist_q  <= '0;
      level_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      hist_q <= {hist_q[FILT-2:0], samp};
      prev_q <= level_q;
      if (!filt_en_i)        level_q <= samp;
      else if (&hist_q)      level_q <= 1'b1;
      else if (~|hist_q)     level_q <= 1'b0;
    end
  end

  assign rise_o = level_q & ~prev_q;
  assign fall_o = ~level_q & prev_q;
endmodule

// File: rtl/timer16_cmp_chan.sv
module timer16_cmp_chan
  import timer16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             tick_i,
  input  logic             force_i,
  input  logic [1:0]       act_i,
  output logic             match_o,
  output logic             pin_o
);
  assign match_o = tick_i && (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o <= 1'b0;
    end else if (match_o || force_i) begin
      case (pin_act_e'(act_i))
        ACT_TOGGLE: pin_o <= ~pin_o;
        ACT_LOW:    pin_o <= 1'b0;
        ACT_HIGH:   pin_o <= 1'b1;
        default:    pin_o <= pin_o;
      endcase
    end
  end
endmodule

// File: rtl/timer16_cc.sv
module timer16_cc
  import timer16_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NC_DEPTH    = 4,
  localparam int unsigned BUS_W      = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       addr_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             presc_stb_i,
  input  logic             ext_clk_i,
  input  logic             cap_i,
  output logic             cmp_a_o,
  output logic             cmp_b_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int unsigned      N_CMP   = 2;

  logic [3:0]           act_q;
  logic [5:0]           ctl_q;
  logic [NUM_FLAGS-1:0] flg_q, msk_q, flag_set, flag_clr;
  logic [CNT_W-1:0]     cnt_q, cap_q, wide_rd;
  logic [CNT_W-1:0]     cmp_q [N_CMP];
  logic [BUS_W-1:0]     tmp_q;
  logic [N_CMP-1:0]     match, force_cmp, pin;
  logic                 ext_rise, ext_fall, cap_rise, cap_fall;
  logic                 tick, cnt_wr, clr_hit, cap_hit, wide_acc;
  logic [2:0]           sel;

  assign sel    = ctl_q[2:0];
  assign cnt_wr = we_i && (addr_i == A_CNT_LO);

  timer16_edge_sync #(.STAGES(SYNC_STAGES), .FILT(NC_DEPTH)) i_ext_sync (
    .clk_i, .rst_ni, .d_i(ext_clk_i), .filt_en_i(1'b0),
    .rise_o(ext_rise), .fall_o(ext_fall)
  );

  timer16_edge_sync #(.STAGES(SYNC_STAGES), .FILT(NC_DEPTH)) i_cap_sync (
    .clk_i, .rst_ni, .d_i(cap_i), .filt_en_i(ctl_q[5]),
    .rise_o(cap_rise), .fall_o(cap_fall)
  );

  always_comb begin
    case (clk_sel_e'(sel))
      CS_SYS:      tick = 1'b1;
      CS_PRE:      tick = presc_stb_i;
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = 1'b0;
    endcase
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    assign force_cmp[k] = we_i && (addr_i == A_PIN_ACT) && wdata_i[6+k];
    timer16_cmp_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i, .rst_ni,
      .cnt_i(cnt_q), .cmp_i(cmp_q[k]), .tick_i(tick),
      .force_i(force_cmp[k]), .act_i(act_q[2*k +: 2]),
      .match_o(match[k]), .pin_o(pin[k])
    );
  end

  assign cmp_a_o = pin[0];
  assign cmp_b_o = pin[1];

  assign clr_hit = ctl_q[3] && match[0];
  assign cap_hit = ctl_q[4] ? cap_rise : cap_fall;

  always_comb begin
    flag_set         = '0;
    flag_set[F_OVF]  = tick && (cnt_q == CNT_MAX);
    flag_set[F_CMPA] = match[0];
    flag_set[F_CMPB] = match[1];
    flag_set[F_CAP]  = cap_hit;
    flag_clr = (we_i && addr_i == A_FLAGS) ? wdata_i[NUM_FLAGS-1:0] : '0;
  end

  // counter, flags, capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
      flg_q <= '0;
    end else begin
      flg_q <= (flg_q & ~flag_clr) | flag_set;
      if (cap_hit) cap_q <= cnt_q;
      if (cnt_wr)       cnt_q <= {tmp_q, wdata_i};
      else if (tick)    cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
    end
  end

  // configuration and compare values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      ctl_q <= '0;
      msk_q <= '0;
      for (int k = 0; k < N_CMP; k++) cmp_q[k] <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_PIN_ACT: act_q    <= wdata_i[3:0];
        A_CTRL:    ctl_q    <= wdata_i[5:0];
        A_MASK:    msk_q    <= wdata_i[NUM_FLAGS-1:0];
        A_CMPA_LO: cmp_q[0] <= {tmp_q, wdata_i};
        A_CMPB_LO: cmp_q[1] <= {tmp_q, wdata_i};
        default: ;
      endcase
    end
  end

  // shared holding byte for split 16-bit access
  assign wide_acc = (addr_i >= A_CNT_LO) && (addr_i <= A_CAP_HI);

  always_comb begin
    case (addr_i[3:1])
      3'd2:    wide_rd = cnt_q;
      3'd3:    wide_rd = cmp_q[0];
      3'd4:    wide_rd = cmp_q[1];
      3'd5:    wide_rd = cap_q;
      default: wide_rd = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q <= '0;
    end else if (wide_acc) begin
      if (we_i && addr_i[0])       tmp_q <= wdata_i;
      else if (re_i && !addr_i[0]) tmp_q <= wide_rd[CNT_W-1:BUS_W];
    end
  end

  always_comb begin
    case (addr_i)
      A_PIN_ACT: rdata_o = BUS_W'(act_q);
      A_CTRL:    rdata_o = BUS_W'(ctl_q);
      A_FLAGS:   rdata_o = BUS_W'(flg_q);
      A_MASK:    rdata_o = BUS_W'(msk_q);
      default:   rdata_o = !wide_acc ? '0 :
                           addr_i[0] ? tmp_q : wide_rd[BUS_W-1:0];
    endcase
  end

  assign irq_o = |(flg_q & msk_q);
endmodule

// File: rtl/timer16_cc_chk.sv
module timer16_cc_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_q,
  input logic             tick,
  input logic             cnt_wr,
  input logic             clr_hit,
  input logic [3:0]       flg_q,
  input logic             irq_o,
  input logic             force_a,
  input logic [1:0]       act_a,
  input logic             pin_a,
  input logic [2:0]       sel
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == 3'd0 && !cnt_wr) |=> $stable(cnt_q));

  // R4
  ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q == CNT_MAX) |=> flg_q[0]);

  // R6
  clr_on_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && !cnt_wr) |=> (cnt_q == '0));

  // R7
  force_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_a && act_a == 2'd3) |=> pin_a);

  // R11
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flg_q != 4'd0));
endmodule

bind timer16_cc timer16_cc_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_q(cnt_q), .tick(tick),
  .cnt_wr(cnt_wr), .clr_hit(clr_hit), .flg_q(flg_q), .irq_o(irq_o),
  .force_a(force_cmp[0]), .act_a(act_q[1:0]), .pin_a(cmp_a_o), .sel(sel)
);

// File: tb/test_timer16_cc.sv
module test_timer16_cc;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic       we_i = 1'b0, re_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       presc_stb_i = 1'b0, ext_clk_i = 1'b0, cap_i = 1'b0;
  logic       cmp_a_o, cmp_b_o, irq_o;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  timer16_cc i_timer16_cc (
    .clk_i, .rst_ni, .addr_i, .we_i, .re_i, .wdata_i, .rdata_o,
    .presc_stb_i, .ext_clk_i, .cap_i, .cmp_a_o, .cmp_b_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; re_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i); re_i = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    bus_wr(lo + 4'd1, v[15:8]);
    bus_wr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    bus_rd(lo, l);
    bus_rd(lo + 4'd1, h);
    v = {h, l};
  endtask

  task automatic pulse_stb(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); presc_stb_i = 1'b1;
      @(negedge clk_i); presc_stb_i = 1'b0;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] b; logic [15:0] w;
    bus_rd(4'd0, b);  chk("R1 pin actions", b, 0);
    bus_rd(4'd1, b);  chk("R1 control", b, 0);
    bus_rd(4'd2, b);  chk("R1 flags", b, 0);
    bus_rd(4'd3, b);  chk("R1 mask", b, 0);
    rd16(4'd4, w);    chk("R1 counter", w, 0);
    rd16(4'd6, w);    chk("R1 compare A", w, 0);
    rd16(4'd10, w);   chk("R1 capture", w, 0);
    chk("R1 irq/pins", {irq_o, cmp_a_o, cmp_b_o}, 0);
  endtask

  task automatic t_sources;
    logic [15:0] w;
    bus_wr(4'd1, 8'h02);
    wr16(4'd4, 16'h0100);
    pulse_stb(5);
    rd16(4'd4, w); chk("R2 prescaler strobes", w, 16'h0105);
    bus_wr(4'd1, 8'h00);
    pulse_stb(3);
    rd16(4'd4, w); chk("R2 stopped code 0", w, 16'h0105);
    bus_wr(4'd1, 8'h07);
    pulse_stb(2);
    rd16(4'd4, w); chk("R2 stopped code 7", w, 16'h0105);
    bus_wr(4'd1, 8'h01);
    bus_wr(4'd1, 8'h00);
    rd16(4'd4, w); chk("R2 system clock two cycles", w, 16'h0107);
  endtask

  task automatic t_ext;
    logic [15:0] w;
    wr16(4'd4, 16'h0000);
    bus_wr(4'd1, 8'h04);
    for (int i = 0; i < 5; i++) begin
      ext_clk_i = 1'b1; wait_cyc(3);
      ext_clk_i = 1'b0; wait_cyc(3);
    end
    wait_cyc(4);
    bus_wr(4'd1, 8'h00);
    rd16(4'd4, w); chk("R3 rising edges", w, 16'd5);
    wr16(4'd4, 16'h0000);
    bus_wr(4'd1, 8'h03);
    ext_clk_i = 1'b1; wait_cyc(6);
    rd16(4'd4, w); chk("R3 falling mode ignores rise", w, 16'd0);
    ext_clk_i = 1'b0; wait_cyc(6);
    rd16(4'd4, w); chk("R3 falling edge counted", w, 16'd1);
    bus_wr(4'd1, 8'h00);
  endtask

  task automatic t_ovf_cmp;
    logic [15:0] w; logic [7:0] b;
    bus_wr(4'd2, 8'h0F);
    wr16(4'd4, 16'hFFFE);
    bus_wr(4'd1, 8'h02);
    pulse_stb(1);
    bus_rd(4'd2, b); chk("R4 no flag at 0xFFFF", b, 0);
    pulse_stb(1);
    rd16(4'd4, w);   chk("R4 wrap to zero", w, 0);
    bus_rd(4'd2, b); chk("R4 overflow flag", b, 8'h01);
    bus_wr(4'd1, 8'h00);
    wr16(4'd6, 16'd3);
    wr16(4'd8, 16'd2);
    wr16(4'd4, 16'd0);
    bus_wr(4'd2, 8'h0F);
    bus_wr(4'd1, 8'h02);
    pulse_stb(2);
    bus_rd(4'd2, b); chk("R5 no match yet", b, 0);
    pulse_stb(1);
    bus_rd(4'd2, b); chk("R5 compare B flag", b, 8'h04);
    pulse_stb(1);
    bus_rd(4'd2, b); chk("R5 compare A flag", b, 8'h06);
    rd16(4'd4, w);   chk("R5 counts past A without clear", w, 16'd4);
    bus_wr(4'd1, 8'h00);
    wr16(4'd4, 16'd0);
    bus_wr(4'd2, 8'h0F);
    bus_wr(4'd1, 8'h0A);
    pulse_stb(4);
    rd16(4'd4, w);   chk("R6 cleared on compare A", w, 16'd0);
    bus_rd(4'd2, b); chk("R6 flags after clear", b, 8'h06);
    pulse_stb(2);
    rd16(4'd4, w);   chk("R6 restarts from zero", w, 16'd2);
    bus_wr(4'd1, 8'h00);
    bus_wr(4'd2, 8'h0F);
  endtask

  task automatic t_pins;
    logic [15:0] w; logic [7:0] b;
    bus_wr(4'd0, 8'h0D);
    bus_wr(4'd0, 8'h4D);
    chk("R7 force A toggles", cmp_a_o, 1'b1);
    bus_wr(4'd0, 8'h8D);
    chk("R7 force B sets", cmp_b_o, 1'b1);
    bus_rd(4'd0, b); chk("R7 force bits read 0", b, 8'h0D);
    bus_rd(4'd2, b); chk("R7 force sets no flag", b, 0);
    wr16(4'd6, 16'd1);
    wr16(4'd4, 16'd0);
    bus_wr(4'd1, 8'h02);
    pulse_stb(2);
    chk("R7 match toggles A", cmp_a_o, 1'b0);
    bus_wr(4'd1, 8'h00);
    rd16(4'd4, w); chk("R7 counter after match", w, 16'd2);
    bus_wr(4'd0, 8'h09);
    bus_wr(4'd0, 8'h89);
    chk("R7 force B drives low", cmp_b_o, 1'b0);
    bus_wr(4'd2, 8'h0F);
  endtask

  task automatic t_capture;
    logic [15:0] w; logic [7:0] b;
    bus_wr(4'd1, 8'h10);
    wr16(4'd4, 16'h1234);
    cap_i = 1'b1; wait_cyc(6);
    rd16(4'd10, w);  chk("R8 rising capture", w, 16'h1234);
    bus_rd(4'd2, b); chk("R8 capture flag", b, 8'h08);
    bus_wr(4'd2, 8'h0F);
    bus_wr(4'd1, 8'h00);
    wr16(4'd4, 16'h0042);
    cap_i = 1'b0; wait_cyc(6);
    rd16(4'd10, w);  chk("R8 falling capture", w, 16'h0042);
    bus_wr(4'd2, 8'h0F);
    wr16(4'd4, 16'h0077);
    cap_i = 1'b1; wait_cyc(6);
    rd16(4'd10, w);  chk("R8 opposite edge ignored", w, 16'h0042);
    bus_rd(4'd2, b); chk("R8 no flag on opposite edge", b, 0);
    bus_wr(4'd1, 8'h30);
    cap_i = 1'b0; wait_cyc(8);
    bus_wr(4'd2, 8'h0F);
    wr16(4'd4, 16'h0011);
    @(negedge clk_i); cap_i = 1'b1;
    wait_cyc(2); cap_i = 1'b0;
    wait_cyc(8);
    rd16(4'd10, w);  chk("R9 short pulse filtered", w, 16'h0042);
    bus_rd(4'd2, b); chk("R9 no flag on short pulse", b, 0);
    cap_i = 1'b1; wait_cyc(8);
    rd16(4'd10, w);  chk("R9 long level accepted", w, 16'h0011);
    cap_i = 1'b0; wait_cyc(8);
    bus_wr(4'd1, 8'h10);
    wr16(4'd4, 16'h0022);
    @(negedge clk_i); cap_i = 1'b1;
    wait_cyc(2); cap_i = 1'b0;
    wait_cyc(8);
    rd16(4'd10, w);  chk("R9 short pulse passes unfiltered", w, 16'h0022);
    bus_wr(4'd2, 8'h0F);
  endtask

  task automatic t_flags_irq;
    logic [7:0] b;
    bus_wr(4'd1, 8'h00);
    bus_wr(4'd2, 8'h0F);
    wr16(4'd4, 16'hFFFF);
    bus_wr(4'd1, 8'h02);
    pulse_stb(1);
    bus_wr(4'd1, 8'h10);
    cap_i = 1'b1; wait_cyc(6);
    bus_wr(4'd1, 8'h00);
    bus_rd(4'd2, b); chk("R10 two flags set", b, 8'h09);
    chk("R11 masked off", irq_o, 1'b0);
    bus_wr(4'd3, 8'h08);
    chk("R11 capture masked in", irq_o, 1'b1);
    bus_wr(4'd2, 8'h01);
    bus_rd(4'd2, b); chk("R10 clear overflow only", b, 8'h08);
    chk("R11 irq held by capture", irq_o, 1'b1);
    bus_wr(4'd2, 8'h00);
    bus_rd(4'd2, b); chk("R10 zero write keeps", b, 8'h08);
    bus_wr(4'd2, 8'h08);
    bus_rd(4'd2, b); chk("R10 capture cleared", b, 0);
    chk("R11 irq low", irq_o, 1'b0);
    bus_wr(4'd3, 8'h00);
  endtask

  task automatic t_wide;
    logic [15:0] w; logic [7:0] b;
    bus_wr(4'd9, 8'h55);
    rd16(4'd8, w); chk("R12 high write alone", w, 16'h0002);
    bus_wr(4'd9, 8'h55);
    bus_wr(4'd8, 8'h66);
    rd16(4'd8, w); chk("R12 commit on low write", w, 16'h5566);
    wr16(4'd4, 16'h12FF);
    bus_wr(4'd1, 8'h02);
    bus_rd(4'd4, b); chk("R12 low byte", b, 8'hFF);
    pulse_stb(1);
    bus_rd(4'd5, b); chk("R12 high byte latched", b, 8'h12);
    bus_wr(4'd1, 8'h00);
    rd16(4'd4, w); chk("R12 fresh read", w, 16'h1300);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);
    t_reset();
    t_sources();
    t_ext();
    t_ovf_cmp();
    t_pins();
    t_capture();
    t_flags_irq();
    t_wide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule